// File: doc/BRIEF.md
# Delayed Branch Next-PC Unit

This unit chooses the next fetch address for a processor with 16-bit instructions whose control transfers are delayed by one instruction. Each cycle in which an instruction issues, the unit receives the instruction word, its address, the four condition flags, the value of the general register named by the instruction, and the current return-pointer value. It recognises five kinds of delayed transfer: the sixteen conditional branches, the call with an immediate displacement, and the register jump, register call and return. When it sees one, it records the transfer and its outcome. Fetch continues to the following instruction, which is the delay slot. Only when that slot instruction issues does the unit apply the redirect.

Calls produce a one-cycle write of the link address to the return pointer. The link address is the address after the delay slot. The unit also reports a slot violation when the slot holds a multi-cycle instruction or another delayed transfer. All outputs are registered. A synchronous active-high reset drops any pending transfer.

Top module: `dbr_next_pc`

## Requirements
- R1: After a synchronous reset, next_pc equals RESET_PC, branch_taken, rp_we and slot_error are 0, and no transfer is pending. A pending transfer is lost.
- R2: An issued instruction that is not a delayed transfer, with nothing pending, gives next_pc = its address + 2 on the following cycle, with branch_taken 0. Upper byte 9F with a sub-code nibble (bits 7:4) of 3 or more is not a transfer.
- R3: When a delayed transfer issues, next_pc first becomes its address + 2. When the next instruction (the slot) issues, next_pc becomes the transfer target if the transfer is taken, and branch_taken pulses for exactly that one cycle.
- R4: Conditional branches have bits 15:12 = F. Bits 11:8 select the condition, with flags = {N,Z,V,C}: 0 always, 1 never, 2 Z, 3 !Z, 4 C, 5 !C, 6 N, 7 !N, 8 V, 9 !V, A N^V, B !(N^V), C (N^V)|Z, D its inverse, E C|Z, F its inverse. The target is address + 2 + 2·sext(bits 7:0).
- R5: The branch condition uses the flags present when the branch issues. Flags at slot issue do not change the decision.
- R6: Bits 15:11 = 11011 form a call whose target is address + 2 + 2·sext(bits 10:0).
- R7: Both call forms raise rp_we for one cycle, in the cycle after the call issues, with rp_wdata = call address + 4.
- R8: Upper byte 9F with bits 7:4 = 0 jumps to ri_value, = 1 calls ri_value, and = 2 returns to rp_value. Each value is taken at issue time.
- R9: slot_error pulses when the slot instruction is flagged multi-cycle. This applies to both taken and not-taken transfers, and the pending redirect still takes effect. A multi-cycle instruction outside a slot raises no error.
- R10: A delayed transfer in a slot raises slot_error. Its own redirect and return-pointer write are dropped, and the instruction after it proceeds sequentially.
- R11: Cycles without issue_valid leave next_pc and the pending state unchanged, with all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| instr | input | 16 | Issued instruction word |
| instr_pc | input | PC_W | Address of the issued instruction |
| flags | input | 4 | Condition flags {N,Z,V,C} |
| slot_multicycle | input | 1 | Issued instruction takes more than one cycle |
| ri_value | input | PC_W | Register selected by the instruction's register field |
| rp_value | input | PC_W | Current return pointer |
| next_pc | output | PC_W | Next fetch address |
| branch_taken | output | 1 | Pulse: redirect applied this cycle |
| rp_we | output | 1 | Pulse: write return pointer |
| rp_wdata | output | PC_W | Link address for the return pointer |
| slot_error | output | 1 | Pulse: illegal instruction in the delay slot |

## Verification
All sixteen condition codes are driven with five flag patterns: none set, all set, Z only, N with C, and V only. These patterns give each code and its inverse opposite outcomes in at least one case, so a swapped or misordered condition shows up. The slot instructions carry the complemented flags, which separates sampling at branch issue from sampling at slot issue. Positive, negative and all-ones displacements are used to catch sign-extension and scaling faults. Idle gaps inside a pending slot, a transfer placed in a slot, and a reset while a transfer is pending check that the pending state is held, suppressed and cleared at the right moments.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [2:0] {
    XF_NONE,
    XF_BCC,
    XF_CALL_IMM,
    XF_JMP_REG,
    XF_CALL_REG,
    XF_RET
  } xfer_kind_e;

  localparam logic [7:0] REG_FORM_BYTE = 8'h9F;
  localparam logic [3:0] BCC_NIBBLE    = 4'hF;
  localparam logic [4:0] CALL_IMM_BITS = 5'b11011;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [15:0]     instr,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] ri_value,
  input  logic [PC_W-1:0] rp_value,
  output xfer_kind_e      kind,
  output logic [3:0]      cond_code,
  output logic [PC_W-1:0] target,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] link_pc,
  output logic            is_xfer,
  output logic            is_call
);
  localparam int EXT8  = PC_W - 9;
  localparam int EXT11 = PC_W - 12;

  logic [PC_W-1:0] disp8, disp11;

  assign disp8   = {{EXT8{instr[7]}}, instr[7:0], 1'b0};
  assign disp11  = {{EXT11{instr[10]}}, instr[10:0], 1'b0};
  assign seq_pc  = pc + PC_W'(2);
  assign link_pc = pc + PC_W'(4);
  assign cond_code = instr[11:8];

  always_comb begin
    kind   = XF_NONE;
    target = seq_pc;
    if (instr[15:12] == BCC_NIBBLE) begin
      kind   = XF_BCC;
      target = seq_pc + disp8;
    end else if (instr[15:11] == CALL_IMM_BITS) begin
      kind   = XF_CALL_IMM;
      target = seq_pc + disp11;
    end else if (instr[15:8] == REG_FORM_BYTE) begin
      case (instr[7:4])
        4'd0: begin kind = XF_JMP_REG;  target = ri_value; end
        4'd1: begin kind = XF_CALL_REG; target = ri_value; end
        4'd2: begin kind = XF_RET;      target = rp_value; end
        default: begin kind = XF_NONE;  target = seq_pc;   end
      endcase
    end
  end

  assign is_xfer = (kind != XF_NONE);
  assign is_call = (kind == XF_CALL_IMM) || (kind == XF_CALL_REG);
endmodule

// File: rtl/dbr_cond.sv
module dbr_cond (
  input  logic [3:0] flags,
  input  logic [3:0] code,
  output logic       take
);
  localparam int NPAIR = 8;

  logic n, z, v, c;
  logic [NPAIR-1:0] base;

  assign {n, z, v, c} = flags;

  // Even codes test a base condition, odd codes its inverse.
  always_comb begin
    base[0] = 1'b1;
    base[1] = z;
    base[2] = c;
    base[3] = n;
    base[4] = v;
    base[5] = v ^ n;
    base[6] = (v ^ n) | z;
    base[7] = c | z;
  end

  assign take = base[code[3:1]] ^ code[0];
endmodule

// File: rtl/dbr_next_pc.sv
module dbr_next_pc
  import dbr_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [15:0]     instr,
  input  logic [PC_W-1:0] instr_pc,
  input  logic [3:0]      flags,
  input  logic            slot_multicycle,
  input  logic [PC_W-1:0] ri_value,
  input  logic [PC_W-1:0] rp_value,
  output logic [PC_W-1:0] next_pc,
  output logic            branch_taken,
  output logic            rp_we,
  output logic [PC_W-1:0] rp_wdata,
  output logic            slot_error
);
  xfer_kind_e      dec_kind;
  logic [3:0]      dec_cond;
  logic [PC_W-1:0] dec_target, dec_seq, dec_link;
  logic            dec_is_xfer, dec_is_call;
  logic            cond_take, xfer_take;

  logic            pend_q, pend_take_q;
  logic [PC_W-1:0] pend_tgt_q;

  dbr_decode #(.PC_W(PC_W)) u_decode (
    .instr    (instr),
    .pc       (instr_pc),
    .ri_value (ri_value),
    .rp_value (rp_value),
    .kind     (dec_kind),
    .cond_code(dec_cond),
    .target   (dec_target),
    .seq_pc   (dec_seq),
    .link_pc  (dec_link),
    .is_xfer  (dec_is_xfer),
    .is_call  (dec_is_call)
  );

  dbr_cond u_cond (
    .flags(flags),
    .code (dec_cond),
    .take (cond_take)
  );

  assign xfer_take = (dec_kind == XF_BCC) ? cond_take : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc      <= RESET_PC;
      branch_taken <= 1'b0;
      rp_we        <= 1'b0;
      rp_wdata     <= '0;
      slot_error   <= 1'b0;
      pend_q       <= 1'b0;
      pend_take_q  <= 1'b0;
      pend_tgt_q   <= '0;
    end else begin
      branch_taken <= 1'b0;
      rp_we        <= 1'b0;
      slot_error   <= 1'b0;
      if (issue_valid) begin
        if (pend_q) begin
          pend_q       <= 1'b0;
          slot_error   <= slot_multicycle | dec_is_xfer;
          branch_taken <= pend_take_q;
          next_pc      <= pend_take_q ? pend_tgt_q : dec_seq;
        end else begin
          next_pc <= dec_seq;
          if (dec_is_xfer) begin
            pend_q      <= 1'b1;
            pend_take_q <= xfer_take;
            pend_tgt_q  <= dec_target;
          end
          if (dec_is_call) begin
            rp_we    <= 1'b1;
            rp_wdata <= dec_link;
          end
        end
      end
    end
  end

  p_seq_after_plain_r2: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !pend_q && !dec_is_xfer) |=>
      (next_pc == $past(instr_pc) + PC_W'(2)) && !branch_taken);

  p_taken_single_r3: assert property (@(posedge clk) disable iff (rst)
    branch_taken |=> !branch_taken);

  p_taken_from_pend_r3: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> $past(pend_q && pend_take_q && issue_valid));

  p_call_link_r7: assert property (@(posedge clk) disable iff (rst)
    rp_we |-> (rp_wdata == $past(instr_pc) + PC_W'(4)));

  p_slot_error_src_r9: assert property (@(posedge clk) disable iff (rst)
    slot_error |-> $past(pend_q && issue_valid));

  p_nested_dropped_r10: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && pend_q) |=> (!pend_q && !rp_we));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> ($stable(next_pc) && !branch_taken && !slot_error && !rp_we));
endmodule

// File: tb/tb_dbr_next_pc.sv
`timescale 1ns/1ps
module tb_dbr_next_pc;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            issue_valid = 1'b0;
  logic [15:0]     instr = '0;
  logic [PC_W-1:0] instr_pc = '0;
  logic [3:0]      flags = '0;
  logic            slot_multicycle = 1'b0;
  logic [PC_W-1:0] ri_value = '0;
  logic [PC_W-1:0] rp_value = '0;
  logic [PC_W-1:0] next_pc;
  logic            branch_taken, rp_we, slot_error;
  logic [PC_W-1:0] rp_wdata;

  always #2.5 clk = ~clk;

  dbr_next_pc #(.PC_W(PC_W), .RESET_PC('0)) dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .instr_pc(instr_pc), .flags(flags), .slot_multicycle(slot_multicycle),
    .ri_value(ri_value), .rp_value(rp_value), .next_pc(next_pc),
    .branch_taken(branch_taken), .rp_we(rp_we), .rp_wdata(rp_wdata),
    .slot_error(slot_error)
  );

  typedef struct {
    logic [PC_W-1:0] npc;
    logic [PC_W-1:0] wdata;
    bit taken, we, err;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  bit              m_pend = 0, m_take = 0;
  logic [PC_W-1:0] m_tgt = '0, m_npc = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [PC_W-1:0] act, input logic [PC_W-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic bit cond_ok(input logic [3:0] code, input logic [3:0] f);
    bit n, z, v, c;
    {n, z, v, c} = f;
    case (code)
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return z;
      4'h3: return !z;
      4'h4: return c;
      4'h5: return !c;
      4'h6: return n;
      4'h7: return !n;
      4'h8: return v;
      4'h9: return !v;
      4'hA: return v ^ n;
      4'hB: return !(v ^ n);
      4'hC: return (v ^ n) | z;
      4'hD: return !((v ^ n) | z);
      4'hE: return c | z;
      default: return !(c | z);
    endcase
  endfunction

  // monitor: compares after each clock edge
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(next_pc == e.npc, e.tag, "next_pc", next_pc, e.npc);
      check(branch_taken == e.taken, e.tag, "branch_taken", PC_W'(branch_taken), PC_W'(e.taken));
      check(slot_error == e.err, e.tag, "slot_error", PC_W'(slot_error), PC_W'(e.err));
      check(rp_we == e.we, e.tag, "rp_we", PC_W'(rp_we), PC_W'(e.we));
      if (e.we) check(rp_wdata == e.wdata, e.tag, "rp_wdata", rp_wdata, e.wdata);
    end
  end

  // driver: drives one cycle and pushes the expected result
  task automatic step(input bit v, input logic [15:0] ins, input logic [PC_W-1:0] pc,
                      input logic [3:0] fl, input bit multi,
                      input logic [PC_W-1:0] ri, input logic [PC_W-1:0] rp,
                      input string tag);
    exp_t e;
    bit xf, call, tk;
    logic [PC_W-1:0] tgt;
    @(negedge clk);
    issue_valid = v; instr = ins; instr_pc = pc; flags = fl;
    slot_multicycle = multi; ri_value = ri; rp_value = rp;
    xf = 0; call = 0; tk = 1; tgt = pc + 2;
    if (ins[15:12] == 4'hF) begin
      xf = 1; tk = cond_ok(ins[11:8], fl);
      tgt = pc + 2 + 2 * {{(PC_W-8){ins[7]}}, ins[7:0]};
    end else if (ins[15:11] == 5'b11011) begin
      xf = 1; call = 1;
      tgt = pc + 2 + 2 * {{(PC_W-11){ins[10]}}, ins[10:0]};
    end else if (ins[15:8] == 8'h9F && ins[7:4] == 4'd0) begin
      xf = 1; tgt = ri;
    end else if (ins[15:8] == 8'h9F && ins[7:4] == 4'd1) begin
      xf = 1; call = 1; tgt = ri;
    end else if (ins[15:8] == 8'h9F && ins[7:4] == 4'd2) begin
      xf = 1; tgt = rp;
    end
    e.tag = tag; e.taken = 0; e.we = 0; e.err = 0; e.wdata = '0; e.npc = m_npc;
    if (v) begin
      if (m_pend) begin
        e.err = multi || xf;
        e.taken = m_take;
        e.npc = m_take ? m_tgt : pc + 2;
        m_pend = 0;
      end else begin
        e.npc = pc + 2;
        if (xf) begin m_pend = 1; m_take = tk; m_tgt = tgt; end
        if (call) begin e.we = 1; e.wdata = pc + 4; end
      end
      m_npc = e.npc;
    end
    exp_q.push_back(e);
  endtask

  task automatic plain(input logic [PC_W-1:0] pc, input bit multi, input logic [3:0] fl,
                       input string tag);
    step(1, 16'h1234, pc, fl, multi, '0, '0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; issue_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    m_pend = 0; m_npc = '0;
    check(next_pc == '0, "R1", "reset next_pc", next_pc, '0);
    check(!branch_taken && !rp_we && !slot_error, "R1", "reset pulses",
          PC_W'({branch_taken, rp_we, slot_error}), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2 plain sequencing, incl. multi-cycle outside a slot (R9) and 9F-3
    plain(32'h40, 1, 4'h0, "R2");
    plain(32'h42, 1, 4'h0, "R9");
    step(1, 16'h9F35, 32'h44, 4'h0, 0, 32'h999, 32'h888, "R2");
    // R3/R4 always branch, positive displacement
    step(1, 16'hF010, 32'h100, 4'h0, 0, '0, '0, "R3");
    plain(32'h102, 0, 4'h0, "R3");
    plain(32'h122, 0, 4'h0, "R3");
    // R4 negative displacement, BEQ taken
    step(1, 16'hF2F0, 32'h200, 4'b0100, 0, '0, '0, "R4");
    plain(32'h202, 0, 4'b0000, "R5");
    // R9 never-branch with multi-cycle slot
    step(1, 16'hF105, 32'h300, 4'h0, 0, '0, '0, "R9");
    plain(32'h302, 1, 4'h0, "R9");
    // R9 taken branch with multi-cycle slot still redirects
    step(1, 16'hF003, 32'h310, 4'h0, 0, '0, '0, "R9");
    plain(32'h312, 1, 4'h0, "R9");
    // R4/R5 every condition with several flag patterns, slot flags inverted
    for (int code = 0; code < 16; code++) begin
      for (int p = 0; p < 5; p++) begin
        logic [3:0] fp;
        logic [PC_W-1:0] bpc;
        case (p)
          0: fp = 4'b0000;
          1: fp = 4'b1111;
          2: fp = 4'b0100;
          3: fp = 4'b1001;
          default: fp = 4'b0010;
        endcase
        bpc = 32'h1000 + PC_W'(code * 64 + p * 8);
        step(1, {4'hF, 4'(code), 8'h08}, bpc, fp, 0, '0, '0, "R4");
        plain(bpc + 2, 0, ~fp, "R5");
      end
    end
    // R6/R7 immediate call forward and with all-ones displacement
    step(1, 16'hD820, 32'h2000, 4'h0, 0, '0, '0, "R6");
    plain(32'h2002, 0, 4'h0, "R6");
    step(1, 16'hDFFF, 32'h2100, 4'h0, 0, '0, '0, "R7");
    plain(32'h2102, 0, 4'h0, "R7");
    // R8 register jump, register call, return
    step(1, 16'h9F03, 32'h3000, 4'h0, 0, 32'h5550, 32'h7770, "R8");
    plain(32'h3002, 0, 4'h0, "R8");
    step(1, 16'h9F14, 32'h3100, 4'h0, 0, 32'h6660, 32'h7770, "R8");
    plain(32'h3102, 0, 4'h0, "R7");
    step(1, 16'h9F20, 32'h3200, 4'h0, 0, 32'h1, 32'h3104, "R8");
    plain(32'h3202, 0, 4'h0, "R8");
    // R10 transfer in slot: error, no link write, own redirect dropped
    step(1, 16'hF004, 32'h4000, 4'h0, 0, '0, '0, "R10");
    step(1, 16'hD840, 32'h4002, 4'h0, 0, '0, '0, "R10");
    plain(32'h400A, 0, 4'h0, "R10");
    plain(32'h400C, 0, 4'h0, "R10");
    // R11 idle cycles while a slot is pending
    step(1, 16'hF006, 32'h5000, 4'h0, 0, '0, '0, "R11");
    step(0, 16'h0000, 32'h0, 4'h0, 0, '0, '0, "R11");
    step(0, 16'hF0FF, 32'h0, 4'h0, 1, '0, '0, "R11");
    plain(32'h5002, 0, 4'h0, "R11");
    // R1 reset drops a pending transfer
    step(1, 16'hF040, 32'h6000, 4'h0, 0, '0, '0, "R1");
    do_reset();
    plain(32'h6002, 0, 4'h0, "R1");
    plain(32'h6004, 0, 4'h0, "R1");
    @(negedge clk);
    issue_valid = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule